// File: doc/BRIEF.md
# Power-On and Pin Reset Sequencer

This block generates the single internal reset of a small 8-bit controller core. It draws on two sources. One is an external active-low reset pin, which asserts reset at once and releases it in step with the clock after a two-stage synchronizer. The other is an optional power-on path. When a configuration bit allows it, a pulse from the supply-threshold detector loads a 12-bit down-counting idle timer with all ones, and reset is held until that timer underflows. After the underflow the power-on path is locked out for as long as the supply-good level stays high. Dropping supply-good clears the lockout and cancels any countdown in progress.

The internal reset is the OR of both sources, so both sources have the same effect. A low pin while the core is halted raises a wake request at once, with no clock edge needed. When reset is released, a one-cycle done strobe goes out. On the next edge the watchdog and clock monitor become armed. While reset is active both are inhibited, and the watchdog service window holds its all-ones (widest) default. Once armed, a clock reported out of range drives the active-low clock-monitor error output. That error stays low until the clock has been back in range for a fixed 24 cycles, a value inside the 16-to-32-cycle band.

Top module: `rst_sequencer`

## Requirements
- R1: A low level on `rst_pin_n` drives `core_rst` high without waiting for a clock edge. After the pin returns high, `core_rst` falls just after the second rising edge that samples the pin high, unless the power-on path still holds it.
- R2: With `por_en` = 1, `supply_ok` = 1 and no lockout, a `supply_trip` high at a rising edge loads the timer with 0xFFF. `core_rst` then stays high for exactly 4096 clock cycles after that edge.
- R3: With `por_en` = 0, `supply_trip` has no effect on `core_rst`.
- R4: After the timer underflows, further `supply_trip` pulses are ignored while `supply_ok` stays high. Taking `supply_ok` low clears the lockout and cancels any countdown.
- R5: A new trip during a countdown reloads the timer to 0xFFF. A pin reset during a countdown neither stops nor restarts it. `core_rst` is the OR of both sources.
- R6: `rst_done` is high for exactly the one cycle that follows the fall of `core_rst`, and at no other time.
- R7: `halt_wake` is high whenever `halt_active` is high and `rst_pin_n` is low, with no clock edge needed.
- R8: While `core_rst` is high, `guards_armed` = 0, `cm_err_n` = 1 and `wd_window` is all ones. `guards_armed` rises at the edge that ends the `rst_done` cycle.
- R9: While armed, a rising edge that samples `clk_ok` low drives `cm_err_n` low. It returns high at the 24th consecutive rising edge that samples `clk_ok` high, and the count restarts whenever `clk_ok` is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| supply_ok | input | 1 | Supply-good level from the threshold detector |
| supply_trip | input | 1 | One-cycle pulse when the supply crosses its threshold |
| por_en | input | 1 | Configuration bit enabling the power-on path |
| halt_active | input | 1 | Core is in HALT mode |
| clk_ok | input | 1 | Clock frequency reported within range |
| core_rst | output | 1 | Internal reset to the chip, active high |
| rst_done | output | 1 | One-cycle strobe after reset release |
| halt_wake | output | 1 | Request to leave HALT |
| guards_armed | output | 1 | Watchdog and clock monitor armed |
| wd_window | output | 2 | Watchdog service-window default (all ones) |
| cm_err_n | output | 1 | Clock-monitor error, active low |

## Verification
The hardest coincidence is the external pin's synchronized release landing on the exact edge where the power-on timer underflows. In that case `core_rst` must fall exactly once and `rst_done` must pulse exactly once. The bench provokes it by holding the pin low through the end of a reloaded countdown and releasing it two edges before the underflow. It then counts the reset cycles (1000 + 4096) and compares every cycle against a behavioural model. A second coincidence, a clock-out-of-range report in the same cycle as a pin reset, is also driven; the reset must win and keep `cm_err_n` high.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Power-on path control flags
    typedef struct packed {
        logic active;   // countdown in progress, holds reset
        logic locked;   // underflow seen, path closed while supply good
    } por_flags_t;

    // Guard (watchdog / clock monitor) flags
    typedef struct packed {
        logic armed;
        logic err;
    } guard_flags_t;

endpackage

// File: rtl/rs_pin_sync.sv
module rs_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic released
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    // Assert immediately with the pin, release through the chain
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign released = chain_q[STAGES-1];
endmodule

// File: rtl/rs_por_timer.sv
module rs_por_timer
    import rstseq_pkg::*;
#(
    parameter int unsigned TMR_W = 12
) (
    input  logic clk,
    input  logic supply_ok,
    input  logic trip,
    input  logic enable,
    output logic active
);
    localparam logic [TMR_W-1:0] PRESET = '1;

    typedef struct packed {
        por_flags_t       flags;
        logic [TMR_W-1:0] tmr;
    } por_state_t;

    por_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enable && trip && !st_q.flags.locked) begin
            st_d.flags.active = 1'b1;
            st_d.tmr          = PRESET;
        end else if (st_q.flags.active) begin
            if (st_q.tmr == '0) begin
                st_d.flags.active = 1'b0;
                st_d.flags.locked = 1'b1;
            end else begin
                st_d.tmr = st_q.tmr - 1'b1;
            end
        end
    end

    // Loss of supply clears the countdown and the lockout
    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) st_q <= '0;
        else            st_q <= st_d;
    end

    assign active = st_q.flags.active;
endmodule

// File: rtl/rs_guard_ctrl.sv
module rs_guard_ctrl
    import rstseq_pkg::*;
#(
    parameter int unsigned WIN_W   = 2,
    parameter int unsigned CM_HOLD = 24
) (
    input  logic             clk,
    input  logic             core_rst,
    input  logic             clk_ok,
    output logic             rst_done,
    output logic             armed,
    output logic [WIN_W-1:0] window,
    output logic             cm_err_n
);
    localparam int unsigned CNT_W = $clog2(CM_HOLD);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CM_HOLD - 1);

    typedef struct packed {
        guard_flags_t     flags;
        logic [CNT_W-1:0] cnt;
    } guard_state_t;

    guard_state_t     st_d, st_q;
    logic             prev_d, prev_q;
    logic [WIN_W-1:0] win_d, win_q;

    // prev_q is forced high by reset and clears one edge after release
    always_comb prev_d = 1'b0;

    always_ff @(posedge clk or posedge core_rst) begin
        if (core_rst) prev_q <= 1'b1;
        else          prev_q <= prev_d;
    end

    assign rst_done = prev_q & ~core_rst;

    always_comb begin
        st_d = st_q;
        if (rst_done) st_d.flags.armed = 1'b1;
        if (st_q.flags.armed && !clk_ok) begin
            st_d.flags.err = 1'b1;
            st_d.cnt       = '0;
        end else if (st_q.flags.err && clk_ok) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.flags.err = 1'b0;
                st_d.cnt       = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge core_rst) begin
        if (core_rst) st_q <= '0;
        else          st_q <= st_d;
    end

    // Service window default: widest setting, restored by every reset
    always_comb win_d = win_q;

    always_ff @(posedge clk or posedge core_rst) begin
        if (core_rst) win_q <= '1;
        else          win_q <= win_d;
    end

    assign armed    = st_q.flags.armed;
    assign window   = win_q;
    assign cm_err_n = ~st_q.flags.err;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TMR_W       = 12,
    parameter int unsigned WIN_W       = 2,
    parameter int unsigned CM_HOLD     = 24
) (
    input  logic             clk,
    input  logic             rst_pin_n,
    input  logic             supply_ok,
    input  logic             supply_trip,
    input  logic             por_en,
    input  logic             halt_active,
    input  logic             clk_ok,
    output logic             core_rst,
    output logic             rst_done,
    output logic             halt_wake,
    output logic             guards_armed,
    output logic [WIN_W-1:0] wd_window,
    output logic             cm_err_n
);
    logic pin_released;
    logic por_active;
    logic ext_rst;

    rs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .pin_n    (rst_pin_n),
        .released (pin_released)
    );

    rs_por_timer #(.TMR_W(TMR_W)) u_por (
        .clk       (clk),
        .supply_ok (supply_ok),
        .trip      (supply_trip),
        .enable    (por_en),
        .active    (por_active)
    );

    assign ext_rst   = ~pin_released;
    assign core_rst  = ext_rst | por_active;
    assign halt_wake = halt_active & ext_rst;

    rs_guard_ctrl #(.WIN_W(WIN_W), .CM_HOLD(CM_HOLD)) u_guard (
        .clk      (clk),
        .core_rst (core_rst),
        .clk_ok   (clk_ok),
        .rst_done (rst_done),
        .armed    (guards_armed),
        .window   (wd_window),
        .cm_err_n (cm_err_n)
    );
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
    parameter int unsigned WIN_W = 2
) (
    input logic             clk,
    input logic             rst_pin_n,
    input logic             supply_trip,
    input logic             por_en,
    input logic             halt_active,
    input logic             clk_ok,
    input logic             core_rst,
    input logic             rst_done,
    input logic             halt_wake,
    input logic             guards_armed,
    input logic [WIN_W-1:0] wd_window,
    input logic             cm_err_n
);
    // R1: pin low always means reset
    a_r1_pin_forces_rst: assert property (@(posedge clk)
        !rst_pin_n |-> core_rst);

    // R3: disabled power-on path cannot start a reset
    a_r3_por_disabled: assert property (@(posedge clk) disable iff (core_rst)
        (!por_en && supply_trip) |=> (!core_rst || !rst_pin_n));

    // R6: strobe lasts one cycle and only follows reset
    a_r6_done_single: assert property (@(posedge clk) disable iff (core_rst)
        rst_done |=> !rst_done);
    a_r6_done_after_rst: assert property (@(posedge clk) disable iff (core_rst)
        rst_done |-> $past(core_rst));

    // R7: wake request on pin low during HALT
    a_r7_halt_wake: assert property (@(posedge clk)
        (halt_active && !rst_pin_n) |-> halt_wake);

    // R8: guards inhibited in reset, armed after the strobe
    a_r8_inhibit: assert property (@(posedge clk)
        core_rst |-> (!guards_armed && cm_err_n && (wd_window == '1)));
    a_r8_arm: assert property (@(posedge clk) disable iff (core_rst)
        rst_done |=> guards_armed);

    // R9: error only from an armed monitor seeing a bad clock
    a_r9_err_cause: assert property (@(posedge clk) disable iff (core_rst)
        $fell(cm_err_n) |-> ($past(guards_armed) && !$past(clk_ok)));
endmodule

bind rst_sequencer rst_sequencer_chk #(.WIN_W(WIN_W)) u_chk (
    .clk          (clk),
    .rst_pin_n    (rst_pin_n),
    .supply_trip  (supply_trip),
    .por_en       (por_en),
    .halt_active  (halt_active),
    .clk_ok       (clk_ok),
    .core_rst     (core_rst),
    .rst_done     (rst_done),
    .halt_wake    (halt_wake),
    .guards_armed (guards_armed),
    .wd_window    (wd_window),
    .cm_err_n     (cm_err_n)
);

// File: tb/rst_sequencer_tb.sv
`timescale 1ns/1ps
module rst_sequencer_tb;
    localparam int HOLD = 24;

    logic clk = 1'b0;
    logic rst_pin_n = 1'b0, supply_ok = 1'b0, supply_trip = 1'b0;
    logic por_en = 1'b1, halt_active = 1'b0, clk_ok = 1'b1;
    logic core_rst, rst_done, halt_wake, guards_armed, cm_err_n;
    logic [1:0] wd_window;

    int n_tests = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    rst_sequencer u_dut (
        .clk(clk), .rst_pin_n(rst_pin_n), .supply_ok(supply_ok),
        .supply_trip(supply_trip), .por_en(por_en), .halt_active(halt_active),
        .clk_ok(clk_ok), .core_rst(core_rst), .rst_done(rst_done),
        .halt_wake(halt_wake), .guards_armed(guards_armed),
        .wd_window(wd_window), .cm_err_n(cm_err_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    bit s1 = 0, s2 = 0, m_act = 0, m_lock = 0, m_core = 1, m_prev = 1, m_arm = 0, m_err = 0;
    int m_tmr = 0, m_cnt = 0;

    always @(posedge clk) begin
        bit o_core, o_done, o_arm, o_err;
        int o_cnt;
        o_core = m_core; o_done = m_prev && !m_core;
        o_arm = m_arm; o_err = m_err; o_cnt = m_cnt;
        cyc++;
        if (!rst_pin_n) begin s1 = 0; s2 = 0; end
        else begin s2 = s1; s1 = 1; end
        if (!supply_ok) begin m_act = 0; m_lock = 0; m_tmr = 0; end
        else if (por_en && supply_trip && !m_lock) begin m_act = 1; m_tmr = 4095; end
        else if (m_act) begin
            if (m_tmr == 0) begin m_act = 0; m_lock = 1; end
            else m_tmr--;
        end
        m_core = !s2 || m_act;
        m_prev = o_core || m_core;
        if (m_core) begin m_arm = 0; m_err = 0; m_cnt = 0; end
        else begin
            if (o_done) m_arm = 1;
            if (o_arm && !clk_ok) begin m_err = 1; m_cnt = 0; end
            else if (o_err && clk_ok) begin
                if (o_cnt == HOLD - 1) begin m_err = 0; m_cnt = 0; end
                else m_cnt = o_cnt + 1;
            end
        end
    end

    // Compare shortly after every edge
    always @(posedge clk) begin
        #1;
        check(core_rst === m_core, "R1 R2 R5 core_rst", int'(core_rst), int'(m_core));
        check(rst_done === (m_prev && !m_core), "R6 rst_done", int'(rst_done), int'(m_prev && !m_core));
        check(guards_armed === m_arm, "R8 guards_armed", int'(guards_armed), int'(m_arm));
        check(cm_err_n === !m_err, "R9 cm_err_n", int'(cm_err_n), int'(!m_err));
        check(wd_window === 2'b11, "R8 wd_window", int'(wd_window), 3);
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic negs(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic trip_count(output int cnt);
        supply_trip = 1'b1;
        @(negedge clk);
        supply_trip = 1'b0;
        cnt = 0;
        while (core_rst && cnt < 20000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        int cnt;
        negs(3);
        check(core_rst === 1'b1 && guards_armed === 1'b0 && cm_err_n === 1'b1,
              "R8 reset state", int'(guards_armed), 0);
        supply_ok = 1'b1;
        negs(2);
        rst_pin_n = 1'b1;
        negs(6);
        check(guards_armed === 1'b1, "R8 armed after release", int'(guards_armed), 1);

        // R9: bad clock, then back in range
        clk_ok = 1'b0;
        negs(3);
        check(cm_err_n === 1'b0, "R9 error low", int'(cm_err_n), 0);
        clk_ok = 1'b1;
        cnt = 0;
        @(negedge clk);
        while (!cm_err_n && cnt < 100) begin cnt++; @(negedge clk); end
        check(cnt == HOLD - 1, "R9 hold length", cnt, HOLD - 1);

        // R2: power-on countdown length
        trip_count(cnt);
        check(cnt == 4096, "R2 countdown", cnt, 4096);
        negs(4);

        // R4: lockout after underflow
        supply_trip = 1'b1; @(negedge clk); supply_trip = 1'b0;
        negs(3);
        check(core_rst === 1'b0, "R4 lockout", int'(core_rst), 0);

        // R4/R3: supply drop clears lockout, disabled path ignores trip
        supply_ok = 1'b0; negs(2); supply_ok = 1'b1;
        por_en = 1'b0;
        supply_trip = 1'b1; @(negedge clk); supply_trip = 1'b0;
        negs(3);
        check(core_rst === 1'b0, "R3 disabled trip", int'(core_rst), 0);
        por_en = 1'b1;

        // R5: reload, pin reset inside countdown, coincident release
        supply_trip = 1'b1; @(negedge clk); supply_trip = 1'b0;
        cnt = 0;
        while (core_rst && cnt < 20000) begin
            cnt++;
            supply_trip = (cnt == 1000);
            if (cnt == 2000) rst_pin_n = 1'b0;
            if (cnt == 2001) rst_pin_n = 1'b1;
            if (cnt == 4000) rst_pin_n = 1'b0;
            if (cnt == 5095) rst_pin_n = 1'b1;
            @(negedge clk);
        end
        supply_trip = 1'b0;
        check(cnt == 5096, "R5 reload and overlap", cnt, 5096);
        negs(4);

        // R7: wake from halt
        halt_active = 1'b1;
        #0.5;
        check(halt_wake === 1'b0, "R7 no wake with pin high", int'(halt_wake), 0);
        rst_pin_n = 1'b0;
        #0.5;
        check(halt_wake === 1'b1, "R7 wake on pin low", int'(halt_wake), 1);
        @(negedge clk);
        rst_pin_n = 1'b1; halt_active = 1'b0;
        negs(6);

        // R9/R8: bad clock reported in the same cycle as a pin reset
        clk_ok = 1'b0; rst_pin_n = 1'b0;
        negs(2);
        check(cm_err_n === 1'b1, "R8 reset beats error", int'(cm_err_n), 1);
        clk_ok = 1'b1; rst_pin_n = 1'b1;
        negs(8);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule